// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the parallel programming and verify port of a small on-chip code store. The store is an array of bytes held in registers; its size is set by an address-width parameter and is 4096 bytes by default. A programmer presents an address, a data byte and a three-bit mode code, then pulses a program strobe. A rising strobe edge in a write mode starts a self-timed operation. Byte writes and lock-bit writes take a fixed number of clock cycles. A chip erase walks the whole array.

While an operation runs, the `ready` output is low. A programmer can also poll the byte being written: the read path returns that byte with bit 7 inverted until the write lands. The read path also returns three fixed signature bytes and the lock bits. Code reads are refused once the two read-protection lock bits are both programmed.

Reads are registered: `rdata` shows the value for the `addr` and `mode` sampled at one rising clock edge, starting just after that edge.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Mode 1 (code write) with a rising `prog_strobe` edge writes `wdata` to the byte at `addr`. Once `ready` returns high, a mode 0 (code read) of that address returns the byte.
- R2: `ready` goes low on the clock edge that samples a rising strobe edge in a write mode. After a code write or a lock write it stays low for exactly WRITE_CYCLES clock cycles.
- R3: While a code write is busy, a mode 0 read of the address being written returns the written byte with bit 7 inverted. Reads of other addresses return their stored bytes. After completion the written address reads back true.
- R4: Mode 2 (chip erase) sets every byte of the array to FFh. It keeps `ready` low for max(ERASE_CYCLES, 2^ADDR_W) cycles.
- R5: A chip erase returns all three lock bits to 0, so code reads are allowed again afterwards.
- R6: In mode 3 (signature), reads at addresses 000h, 100h and 200h return 1Eh, 51h and 06h. Any other address returns FFh. Signature reads work whatever the lock bits hold.
- R7: Mode 4 (lock write) ORs `wdata[2:0]` into the lock bits, where bit 0 is read lock A, bit 1 is read lock B and bit 2 is a third lock bit. Mode 5 (lock read) always returns {5'b0, lock bits}.
- R8: When lock bits 0 and 1 are both set, every mode 0 read returns FFh. One of them alone blocks nothing.
- R9: A strobe edge that arrives while `ready` is low is ignored: nothing is written, and the running operation keeps its length.
- R10: After reset, `ready` is 1, `rdata` is FFh and the lock bits are 0. Modes 6 and 7 read FFh. `rdata` follows `addr`/`mode` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Data byte for code writes; bits 2:0 for lock writes |
| mode | input | 3 | Mode code (0 code read, 1 code write, 2 erase, 3 signature, 4 lock write, 5 lock read) |
| prog_strobe | input | 1 | Program strobe; the active edge starts a write-mode operation |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | High when idle, low while an operation runs |

## Verification
A strobe driven between clock edges is seen at the next rising edge. `ready` is already low when sampled at the following falling edge. It is then counted low for exactly WRITE_CYCLES falling edges after a byte or lock write, and for the erase length after an erase. Each read sets `addr` and `mode` at a falling edge and compares `rdata` at the next falling edge, one register stage later. Polling reads are placed inside the busy window, and the strobe sent while busy is timed to land in that window. Lock state is checked by reading it back through mode 5, and by code reads of bytes whose values are known.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [2:0] {
      MD_RD_CODE = 3'd0,
      MD_WR_CODE = 3'd1,
      MD_ERASE   = 3'd2,
      MD_RD_SIG  = 3'd3,
      MD_WR_LOCK = 3'd4,
      MD_RD_LOCK = 3'd5
   } fp_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROG  = 2'd1,
      ST_LOCK  = 2'd2,
      ST_ERASE = 2'd3
   } fp_state_e;

   localparam logic [7:0] FP_BLANK = 8'hFF;
   localparam logic [7:0] FP_SIG0  = 8'h1E;
   localparam logic [7:0] FP_SIG1  = 8'h51;
   localparam logic [7:0] FP_SIG2  = 8'h06;
   localparam int unsigned FP_LOCK_W = 3;

   function automatic int unsigned fp_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge #(
   parameter int STROBE_POL = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fire
);
   localparam logic IDLE_LVL = (STROBE_POL != 0) ? 1'b0 : 1'b1;

   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= IDLE_LVL;
      else        strobe_q <= strobe;
   end

   generate
      if (STROBE_POL != 0) begin : g_rise
         assign fire = strobe & ~strobe_q;
      end else begin : g_fall
         assign fire = ~strobe & strobe_q;
      end
   endgenerate

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int WRITE_CYCLES = 40,
   parameter int ERASE_LEN    = 5000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  logic [2:0]           mode,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           wdata,
   output logic                 busy,
   output logic                 prog_busy,
   output logic [ADDR_W-1:0]    pend_addr,
   output logic [7:0]           pend_data,
   output logic [FP_LOCK_W-1:0] lock_bits,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_waddr,
   output logic [7:0]           mem_wdata
);
   localparam int unsigned LONGEST = fp_max(WRITE_CYCLES, ERASE_LEN);
   localparam int CNT_W = $clog2(LONGEST + 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
   localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_LEN - 1);

   fp_state_e          st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [ADDR_W-1:0]  ers_ptr_q;
   logic               cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         pend_addr <= '0;
         pend_data <= '0;
         lock_bits <= '0;
         ers_ptr_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (fire) begin
                  case (fp_mode_e'(mode))
                     MD_WR_CODE: begin
                        st_q      <= ST_PROG;
                        cnt_q     <= WR_LOAD;
                        pend_addr <= addr;
                        pend_data <= wdata;
                     end
                     MD_WR_LOCK: begin
                        st_q      <= ST_LOCK;
                        cnt_q     <= WR_LOAD;
                        pend_data <= wdata;
                     end
                     MD_ERASE: begin
                        st_q      <= ST_ERASE;
                        cnt_q     <= ER_LOAD;
                        ers_ptr_q <= '0;
                     end
                     default: ;
                  endcase
               end
            end
            ST_PROG, ST_LOCK: begin
               if (cnt_zero) begin
                  st_q <= ST_IDLE;
                  if (st_q == ST_LOCK) lock_bits <= lock_bits | pend_data[FP_LOCK_W-1:0];
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_ERASE: begin
               if (ers_ptr_q != '1) ers_ptr_q <= ers_ptr_q + 1'b1;
               if (cnt_zero) begin
                  st_q      <= ST_IDLE;
                  lock_bits <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_waddr = pend_addr;
      mem_wdata = pend_data;
      if (st_q == ST_ERASE) begin
         mem_we    = 1'b1;
         mem_waddr = ers_ptr_q;
         mem_wdata = FP_BLANK;
      end else if (st_q == ST_PROG && cnt_zero) begin
         mem_we = 1'b1;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign prog_busy = (st_q == ST_PROG);

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           mode,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           mem_byte,
   input  logic [FP_LOCK_W-1:0] lock_bits,
   input  logic                 code_locked,
   input  logic                 prog_busy,
   input  logic [ADDR_W-1:0]    pend_addr,
   input  logic [7:0]           pend_data,
   output logic [7:0]           rdata
);
   localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(12'h000);
   localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(12'h100);
   localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(12'h200);

   logic [7:0] rd_next;

   always_comb begin
      rd_next = FP_BLANK;
      case (fp_mode_e'(mode))
         MD_RD_CODE: begin
            if (code_locked)                           rd_next = FP_BLANK;
            else if (prog_busy && addr == pend_addr)   rd_next = {~pend_data[7], pend_data[6:0]};
            else                                       rd_next = mem_byte;
         end
         MD_RD_SIG: begin
            if      (addr == SIG_A0) rd_next = FP_SIG0;
            else if (addr == SIG_A1) rd_next = FP_SIG1;
            else if (addr == SIG_A2) rd_next = FP_SIG2;
            else                     rd_next = FP_BLANK;
         end
         MD_RD_LOCK: rd_next = {{(8-FP_LOCK_W){1'b0}}, lock_bits};
         default:    rd_next = FP_BLANK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= FP_BLANK;
      else        rdata <= rd_next;
   end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int WRITE_CYCLES = 40,
   parameter int ERASE_CYCLES = 5000,
   parameter int STROBE_POL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [2:0]        mode,
   input  logic              prog_strobe,
   output logic [7:0]        rdata,
   output logic              ready
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int ERASE_LEN = int'(fp_max(ERASE_CYCLES, DEPTH));

   generate
      if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr_w
         $error("flash_prog_ctrl: ADDR_W must lie in 10..16 so the signature addresses exist");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_write
         $error("flash_prog_ctrl: WRITE_CYCLES must be at least 1");
      end
      if (ERASE_CYCLES < 1) begin : g_bad_erase
         $error("flash_prog_ctrl: ERASE_CYCLES must be at least 1");
      end
   endgenerate

   logic                 fire;
   logic                 busy;
   logic                 prog_busy;
   logic [ADDR_W-1:0]    pend_addr;
   logic [7:0]           pend_data;
   logic [FP_LOCK_W-1:0] lock_bits;
   logic                 mem_we;
   logic [ADDR_W-1:0]    mem_waddr;
   logic [7:0]           mem_wdata;
   logic [7:0]           mem_byte;
   logic                 code_locked;

   assign code_locked = lock_bits[0] & lock_bits[1];
   assign ready       = ~busy;

   flash_strobe_edge #(.STROBE_POL(STROBE_POL)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (prog_strobe),
      .fire   (fire)
   );

   flash_seq #(
      .ADDR_W       (ADDR_W),
      .WRITE_CYCLES (WRITE_CYCLES),
      .ERASE_LEN    (ERASE_LEN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .mode      (mode),
      .addr      (addr),
      .wdata     (wdata),
      .busy      (busy),
      .prog_busy (prog_busy),
      .pend_addr (pend_addr),
      .pend_data (pend_data),
      .lock_bits (lock_bits),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata)
   );

   flash_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (addr),
      .rdata (mem_byte)
   );

   flash_read_path #(.ADDR_W(ADDR_W)) u_read (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .addr        (addr),
      .mem_byte    (mem_byte),
      .lock_bits   (lock_bits),
      .code_locked (code_locked),
      .prog_busy   (prog_busy),
      .pend_addr   (pend_addr),
      .pend_data   (pend_data),
      .rdata       (rdata)
   );

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
   parameter int ADDR_W       = 12,
   parameter int WRITE_CYCLES = 40,
   parameter int STROBE_POL   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_strobe,
   input logic [2:0]        mode,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rdata,
   input logic              ready,
   input logic              locked
);
   localparam logic ACT_LVL = (STROBE_POL != 0) ? 1'b1 : 1'b0;

   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= '0;
      else if (ready)          low_cnt <= '0;
      else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
   end

   // R2: ready only drops after the strobe stood at its active level
   assert_ready_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> ($past(prog_strobe) == ACT_LVL));

   // R2: no operation finishes before the write duration has elapsed
   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (low_cnt >= 16'(WRITE_CYCLES)));

   // R8: locked code reads come back blank
   assert_lock_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode == 3'd0 && locked) |-> (rdata == 8'hFF));

   // R6: first signature byte
   assert_sig_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode == 3'd3 && addr == '0) |-> (rdata == 8'h1E));

   // R7: lock read leaves the upper bits clear
   assert_lock_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode == 3'd5) |-> (rdata[7:3] == 5'd0));

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
   .ADDR_W       (ADDR_W),
   .WRITE_CYCLES (WRITE_CYCLES),
   .STROBE_POL   (STROBE_POL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .prog_strobe (prog_strobe),
   .mode        (mode),
   .addr        (addr),
   .rdata       (rdata),
   .ready       (ready),
   .locked      (code_locked)
);

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;

   localparam int AW   = 12;
   localparam int W    = 40;
   localparam int ECYC = 5000;
   localparam int ELEN = (ECYC > (1 << AW)) ? ECYC : (1 << AW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [2:0]    mode = 3'd0;
   logic          prog_strobe = 1'b0;
   logic [7:0]    rdata;
   logic          ready;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_prog_ctrl #(
      .ADDR_W(AW), .WRITE_CYCLES(W), .ERASE_CYCLES(ECYC), .STROBE_POL(1)
   ) u_flash_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mode(mode),
      .prog_strobe(prog_strobe), .rdata(rdata), .ready(ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic strobe_op(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
      mode = m; addr = a; wdata = d; prog_strobe = 1'b1;
      @(negedge clk);
      prog_strobe = 1'b0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready && n < 20000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd_chk(input string req, input logic [2:0] m, input logic [AW-1:0] a,
                         input logic [7:0] exp);
      mode = m; addr = a;
      @(negedge clk);
      chk(req, int'(rdata), int'(exp));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R10 ready after reset", int'(ready), 1);
      chk("R10 rdata after reset", int'(rdata), 8'hFF);
      rd_chk("R10 lock bits after reset", 3'd5, '0, 8'h00);
   endtask

   task automatic t_erase();
      int n;
      strobe_op(3'd2, '0, 8'h00);
      chk("R2 ready low after erase strobe", int'(ready), 0);
      wait_ready(n);
      chk("R4 erase busy length", n, ELEN);
      rd_chk("R4 erased byte 000", 3'd0, 12'h000, 8'hFF);
      rd_chk("R4 erased byte ABC", 3'd0, 12'hABC, 8'hFF);
      rd_chk("R4 erased byte FFF", 3'd0, 12'hFFF, 8'hFF);
   endtask

   task automatic t_program();
      int n;
      strobe_op(3'd1, 12'h000, 8'h00);
      chk("R2 ready low after write strobe", int'(ready), 0);
      wait_ready(n);
      chk("R2 write busy length", n, W);
      strobe_op(3'd1, 12'h7FF, 8'h5A); wait_ready(n);
      strobe_op(3'd1, 12'hFFF, 8'hC3); wait_ready(n);
      rd_chk("R1 byte 000", 3'd0, 12'h000, 8'h00);
      rd_chk("R1 byte 7FF", 3'd0, 12'h7FF, 8'h5A);
      rd_chk("R1 byte FFF", 3'd0, 12'hFFF, 8'hC3);
      rd_chk("R10 mode 6 reads blank", 3'd6, 12'h7FF, 8'hFF);
      rd_chk("R10 mode 7 reads blank", 3'd7, 12'h000, 8'hFF);
   endtask

   task automatic t_poll();
      int n;
      strobe_op(3'd1, 12'h123, 8'hA5);
      rd_chk("R3 poll of A5 shows bit7 inverted", 3'd0, 12'h123, 8'h25);
      rd_chk("R3 other byte unaffected while busy", 3'd0, 12'h7FF, 8'h5A);
      wait_ready(n);
      rd_chk("R3 true data after completion", 3'd0, 12'h123, 8'hA5);
      strobe_op(3'd1, 12'h124, 8'h3C);
      rd_chk("R3 poll of 3C shows bit7 inverted", 3'd0, 12'h124, 8'hBC);
      wait_ready(n);
      rd_chk("R3 true data 3C", 3'd0, 12'h124, 8'h3C);
   endtask

   task automatic t_ignore_busy();
      int n;
      strobe_op(3'd1, 12'h010, 8'h11);
      @(negedge clk);
      strobe_op(3'd1, 12'h020, 8'h22);
      wait_ready(n);
      chk("R9 busy length unchanged by second strobe", n, W - 2);
      rd_chk("R9 ignored write left byte blank", 3'd0, 12'h020, 8'hFF);
      rd_chk("R9 first write landed", 3'd0, 12'h010, 8'h11);
      strobe_op(3'd1, 12'h030, 8'h33);
      @(negedge clk);
      strobe_op(3'd2, 12'h000, 8'h00);
      wait_ready(n);
      chk("R9 erase strobe while busy ignored", n, W - 2);
      rd_chk("R9 byte 7FF survives ignored erase", 3'd0, 12'h7FF, 8'h5A);
   endtask

   task automatic t_signature();
      rd_chk("R6 signature 000", 3'd3, 12'h000, 8'h1E);
      rd_chk("R6 signature 100", 3'd3, 12'h100, 8'h51);
      rd_chk("R6 signature 200", 3'd3, 12'h200, 8'h06);
      rd_chk("R6 signature other 300", 3'd3, 12'h300, 8'hFF);
      rd_chk("R6 signature other 001", 3'd3, 12'h001, 8'hFF);
   endtask

   task automatic t_lock();
      int n;
      strobe_op(3'd4, '0, 8'h01);
      wait_ready(n);
      chk("R2 lock write busy length", n, W);
      rd_chk("R7 lock read after LB bit0", 3'd5, '0, 8'h01);
      rd_chk("R8 single lock bit does not block", 3'd0, 12'h7FF, 8'h5A);
      strobe_op(3'd4, '0, 8'h02); wait_ready(n);
      rd_chk("R7 lock read after bit1", 3'd5, '0, 8'h03);
      rd_chk("R8 locked read 7FF blank", 3'd0, 12'h7FF, 8'hFF);
      rd_chk("R8 locked read 000 blank", 3'd0, 12'h000, 8'hFF);
      rd_chk("R6 signature while locked", 3'd3, 12'h100, 8'h51);
      strobe_op(3'd4, '0, 8'hFC); wait_ready(n);
      rd_chk("R7 lock bit2 ORed in, upper wdata ignored", 3'd5, '0, 8'h07);
      strobe_op(3'd2, '0, 8'h00);
      wait_ready(n);
      chk("R4 second erase busy length", n, ELEN);
      rd_chk("R5 lock bits cleared by erase", 3'd5, '0, 8'h00);
      rd_chk("R5 erased byte after unlock", 3'd0, 12'h7FF, 8'hFF);
      strobe_op(3'd1, 12'h7FF, 8'h77); wait_ready(n);
      rd_chk("R5 code readable after erase", 3'd0, 12'h7FF, 8'h77);
   endtask

   initial begin
      t_reset();
      t_erase();
      t_program();
      t_poll();
      t_ignore_busy();
      t_signature();
      t_lock();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired before the test sequence ended");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule